// File: doc/BRIEF.md
# Start/Stop Framing Serializer with Alignment Word and Run-Start Marker

This block turns a stream of parallel data words into a single serial bit stream, one bit per clock. Every word is wrapped in a 20-bit frame: a leading start bit, the 18 data bits least significant first, and a trailing stop bit. The block runs its own bit counter and raises a one-cycle take pulse once every 20 clocks. The upstream logic must hold the next word and the alignment request steady while that pulse is high. While the alignment request is high, a fixed word goes out in place of the user word. Its long runs of ones and zeros let a far-end receiver find the frame boundary quickly during link bring-up.

Alongside each serial bit the block gives a marker that is high when that bit starts a new run of equal bits. An output driver uses the marker to boost the first bit of each run. The marker compares against the bit actually sent before, including across frame boundaries. A loopback control sends the stream to a local loopback output and reports the external output as disabled.

Top module: `ser_frame_tx`

## Requirements
- R1: Each frame is 20 consecutive clocks on the stream. The start bit (1) comes first, then data bit 0 through data bit 17, then the stop bit (0). Frames follow each other with no gap.
- R2: `word_take` is high for one cycle in every 20. `tx_word` and `sync_req` are sampled at the rising edge that ends that cycle, and the start bit appears right after that edge. Changes to `tx_word` at any other time have no effect on the stream.
- R3: When `sync_req` is sampled high, the payload is the alignment word, whatever `tx_word` holds. In that word, data bits 0 to 8 are 0 and data bits 9 to 17 are 1.
- R4: With `pre_en` high, `pre_flag` is 1 on a bit whose value differs from the bit sent just before it, and 0 when the value is the same. This holds across frame boundaries, and a run of one bit is flagged.
- R5: The first bit sent after reset is always flagged while `pre_en` is high.
- R6: With `pre_en` low, `pre_flag` is 0.
- R7: With `loop_en` high, `loop_out` carries the stream, `ser_out` is 0 and `ser_oe` is 0. With `loop_en` low, `ser_out` carries the stream, `loop_out` is 0 and `ser_oe` is 1.
- R8: While `rst` is high, the stream is 0 and `pre_flag` is 0. In the first cycle after `rst` falls, `word_take` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_word | input | 18 | Parallel data word, sampled at the end of a `word_take` cycle |
| sync_req | input | 1 | Send the alignment word instead of `tx_word` |
| pre_en | input | 1 | Enable the run-start marker |
| loop_en | input | 1 | Send the stream to `loop_out` instead of `ser_out` |
| word_take | output | 1 | High in the cycle whose closing edge captures the next word |
| ser_out | output | 1 | External serial bit |
| ser_oe | output | 1 | External serial output enabled |
| loop_out | output | 1 | Loopback serial bit |
| pre_flag | output | 1 | The current bit starts a run |

## Verification
The run-start marker and the frame turnover land in the same cycle at every frame boundary. The stop bit of one frame (0) is followed at once by the start bit of the next (1), so the marker must react to a change that spans two frames. The bench sends frames back to back under every `pre_en` and `loop_en` setting: walking-one words, all zeros, all ones, alternating patterns, pseudo-random words and alignment words. It also changes `tx_word` in the middle of frames. A reference model in the bench keeps its own last-sent bit, so each marker value at a boundary is checked against the end of the previous frame and not against a fresh frame start.

// File: rtl/ser_frame_pkg.sv
package ser_frame_pkg;
  localparam logic START_BIT = 1'b1;
  localparam logic STOP_BIT  = 1'b0;

  typedef enum logic {LANE_EXT = 1'b0, LANE_LOOP = 1'b1} lane_mode_e;
endpackage

// File: rtl/ser_frame_build.sv
module ser_frame_build
  import ser_frame_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic [DATA_W-1:0] word,
  input  logic              sync,
  output logic [DATA_W+1:0] frame
);
  localparam int FRAME_W = DATA_W + 2;

  // alignment word: lower half zeros, upper half ones (bit 0 leaves first)
  function automatic logic [DATA_W-1:0] align_word();
    logic [DATA_W-1:0] v;
    for (int i = 0; i < DATA_W; i++) v[i] = (i >= DATA_W / 2);
    return v;
  endfunction

  logic [DATA_W-1:0] payload;

  always_comb begin
    payload = sync ? align_word() : word;
    frame   = {STOP_BIT, payload, START_BIT};
  end

  always_comb begin
    if (sync) assert (payload[0] == 1'b0 && payload[DATA_W-1] == 1'b1); // R3
    assert (frame[0] == START_BIT && frame[FRAME_W-1] == STOP_BIT); // R1
  end
endmodule

// File: rtl/ser_shift_core.sv
module ser_shift_core #(
  parameter int FRAME_W = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FRAME_W-1:0] frame,
  output logic               take,
  output logic               cur_bit,
  output logic               next_bit
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-2:0] sh_q;
  logic               bit_q;
  logic               started_q;

  assign take     = (cnt_q == '0);
  assign cur_bit  = bit_q;
  assign next_bit = take ? frame[0] : sh_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      sh_q      <= '0;
      bit_q     <= 1'b0;
      started_q <= 1'b0;
    end else begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      bit_q <= next_bit;
      if (take) begin
        sh_q      <= frame[FRAME_W-1:1];
        started_q <= 1'b1;
      end else begin
        sh_q <= {1'b0, sh_q[FRAME_W-2:1]};
      end
    end
  end

  AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    take |=> !take); // R2
  AST_START_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
    take |=> cur_bit); // R1
  AST_STOP_BEFORE_TAKE: assert property (@(posedge clk) disable iff (rst)
    (take && started_q) |-> !cur_bit); // R1
endmodule

// File: rtl/ser_run_mark.sv
module ser_run_mark (
  input  logic clk,
  input  logic rst,
  input  logic cur_bit,
  input  logic next_bit,
  output logic run_start,
  output logic sent_any
);
  logic mark_q;
  logic sent_q;

  assign run_start = mark_q;
  assign sent_any  = sent_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mark_q <= 1'b0;
      sent_q <= 1'b0;
    end else begin
      mark_q <= !sent_q || (next_bit != cur_bit);
      sent_q <= 1'b1;
    end
  end

  AST_SAME_BIT_UNMARKED: assert property (@(posedge clk) disable iff (rst)
    (sent_q && $past(sent_q) && cur_bit == $past(cur_bit)) |-> !run_start); // R4
  AST_CHANGED_BIT_MARKED: assert property (@(posedge clk) disable iff (rst)
    (sent_q && $past(sent_q) && cur_bit != $past(cur_bit)) |-> run_start); // R4
  AST_FIRST_BIT_MARKED: assert property (@(posedge clk) disable iff (rst)
    $rose(sent_q) |-> run_start); // R5
endmodule

// File: rtl/ser_frame_tx.sv
module ser_frame_tx
  import ser_frame_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              sync_req,
  input  logic              pre_en,
  input  logic              loop_en,
  output logic              word_take,
  output logic              ser_out,
  output logic              ser_oe,
  output logic              loop_out,
  output logic              pre_flag
);
  localparam int FRAME_W = DATA_W + 2;

  logic [FRAME_W-1:0] frame_w;
  logic               stream_bit;
  logic               next_bit;
  logic               run_start;
  logic               sent_any;
  lane_mode_e         lane;

  ser_frame_build #(.DATA_W(DATA_W)) build_i (
    .word (tx_word),
    .sync (sync_req),
    .frame(frame_w)
  );

  ser_shift_core #(.FRAME_W(FRAME_W)) shift_i (
    .clk     (clk),
    .rst     (rst),
    .frame   (frame_w),
    .take    (word_take),
    .cur_bit (stream_bit),
    .next_bit(next_bit)
  );

  ser_run_mark mark_i (
    .clk      (clk),
    .rst      (rst),
    .cur_bit  (stream_bit),
    .next_bit (next_bit),
    .run_start(run_start),
    .sent_any (sent_any)
  );

  always_comb begin
    lane     = loop_en ? LANE_LOOP : LANE_EXT;
    ser_oe   = (lane == LANE_EXT);
    ser_out  = (lane == LANE_EXT)  ? stream_bit : 1'b0;
    loop_out = (lane == LANE_LOOP) ? stream_bit : 1'b0;
    pre_flag = pre_en && run_start;
  end

  AST_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ser_out, loop_out})); // R7
  AST_FLAG_NEEDS_BIT: assert property (@(posedge clk) disable iff (rst)
    (pre_flag && !sent_any) |-> 1'b0); // R5
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!ser_out && !loop_out && !pre_flag)); // R8
endmodule

// File: tb/ser_frame_tx_tb_top.sv
`timescale 1ns/1ps
module ser_frame_tx_tb_top;
  localparam int DW = 18;
  localparam int FW = DW + 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] tx_word = '0;
  logic          sync_req = 1'b0;
  logic          pre_en = 1'b1;
  logic          loop_en = 1'b0;
  logic          word_take, ser_out, ser_oe, loop_out, pre_flag;

  int n_run  = 0;
  int n_fail = 0;
  logic ref_prev  = 1'b0;
  logic ref_first = 1'b1;

  always #4 clk = ~clk;

  ser_frame_tx #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .tx_word(tx_word), .sync_req(sync_req),
    .pre_en(pre_en), .loop_en(loop_en), .word_take(word_take),
    .ser_out(ser_out), .ser_oe(ser_oe), .loop_out(loop_out), .pre_flag(pre_flag)
  );

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send_frame(logic [DW-1:0] w, logic s, logic pe, logic lp, logic scramble);
    logic [DW-1:0] pay;
    while (!word_take) @(negedge clk);
    check("R2 take", word_take, 1);
    tx_word = w; sync_req = s; pre_en = pe; loop_en = lp;
    pay = s ? DW'((1 << DW) - 1) ^ DW'((1 << (DW / 2)) - 1) : w;
    for (int i = 0; i < FW; i++) begin
      logic b, fl;
      @(negedge clk);
      if (scramble) begin tx_word = ~tx_word ^ DW'(i * 7919); sync_req = ~sync_req & ~s; end
      b  = (i == 0) ? 1'b1 : (i == FW - 1) ? 1'b0 : pay[i-1];
      fl = pe & (ref_first | (b != ref_prev));
      ref_prev = b; ref_first = 1'b0;
      if (lp) begin
        check("R7 loop_out", loop_out, b);
        check("R7 ser_out idle", ser_out, 0);
        check("R7 ser_oe", ser_oe, 0);
      end else begin
        check(s ? "R3 sync bit" : "R1 frame bit", ser_out, b);
        check("R7 loop idle", loop_out, 0);
        check("R7 ser_oe", ser_oe, 1);
      end
      check(pe ? "R4 run flag" : "R6 flag off", pre_flag, fl);
      if (i < FW - 1) check("R2 take low", word_take, 0);
    end
  endtask

  task automatic do_reset(int cyc);
    rst = 1'b1;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      check("R8 ser reset", ser_out | loop_out, 0);
      check("R8 flag reset", pre_flag, 0);
    end
    rst = 1'b0;
    check("R8 take after reset", word_take, 1);
    ref_first = 1'b1; ref_prev = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] lcg;
    do_reset(3);
    // R5: first frame flags its first bit
    send_frame('0, 1'b0, 1'b1, 1'b0, 1'b0);
    send_frame('1, 1'b0, 1'b1, 1'b0, 1'b0);
    send_frame(DW'(18'h2AAAA), 1'b0, 1'b1, 1'b0, 1'b0);
    send_frame(DW'(18'h15555), 1'b0, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < DW; k++)
      send_frame(DW'(1) << k, 1'b0, 1'b1, 1'b0, 1'b0);
    // R3: alignment word ignores tx_word
    send_frame(DW'(18'h1234F), 1'b1, 1'b1, 1'b0, 1'b0);
    send_frame('1, 1'b1, 1'b1, 1'b1, 1'b0);
    // R2: mid-frame changes have no effect
    send_frame(DW'(18'h0F0F3), 1'b0, 1'b1, 1'b0, 1'b1);
    // R6 and R7 combinations
    lcg = DW'(18'h1ACE5);
    for (int k = 0; k < 16; k++) begin
      lcg = DW'(lcg * 69069 + 12345);
      send_frame(lcg, 1'b0, k[0], k[1], k[2]);
    end
    // R8: reset in the middle of a frame, R5 again after it
    repeat (7) @(negedge clk);
    do_reset(2);
    send_frame(DW'(18'h3C3C3), 1'b0, 1'b1, 1'b0, 1'b0);
    send_frame('0, 1'b1, 1'b0, 1'b0, 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule